// File: doc/BRIEF.md
# Common-Page Program Memory Bank Decoder

This block widens the program address of a 16-bit microcontroller to a 512KB code store built from sixteen 32KB pages. A general-purpose output port supplies a four-bit page number. The block registers that number when the program-store strobe is released. It then drives the four upper memory address lines. The CPU's lower 15 address lines go straight to the memory, so the full memory address is the page number followed by those 15 bits.

The lower half of code space (CPU address bit 15 low) always reads page 0, whatever page is latched. Interrupt vectors and service routines kept there are therefore reachable from every page without any software action. Fetches from the upper half (bit 15 high) go to the latched page. A page value n thus covers memory bytes n*32K through n*32K+7FFFh.

The strobe is active low. Its rising edge is found by a synchronous edge detector on the system clock, so a new port value takes effect only at the fetch after the next strobe release.

Top module: `codebank_map`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first strobe release, the latched page is 0. An upper-half fetch therefore drives `mem_page` = 0, so the reset vector comes from page 0.
- R2: When `cpu_addr_hi` is 0, `mem_page` is 0 in every cycle, whatever the latched page or `page_sel` is.
- R3: When `cpu_addr_hi` is 1, `mem_page` equals the latched page. Page value n selects memory byte addresses n*32768 to n*32768+32767.
- R4: The latched page changes only on a strobe release, which is a clock edge where `fetch_strobe_n` is 1 and was 0 at the previous edge. A `page_sel` change with no release leaves `mem_page` unchanged.
- R5: The value captured is `page_sel` as sampled at the clock edge that detects the release. Values present only while the strobe is low are not kept.
- R6: A newly captured page appears on `mem_page` in the cycle after the detecting clock edge. Until then the previous page stays in effect.
- R7: A falling strobe edge (1 to 0) does not change the latched page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_strobe_n | input | 1 | Active-low program-store strobe |
| cpu_addr_hi | input | 1 | CPU code address bit 15 |
| page_sel | input | PAGE_BITS | Page number from general-purpose port |
| mem_page | output | PAGE_BITS | Upper memory address lines (bit 15 upward) |

## Verification
Assertions check on every cycle that the low half always maps to page 0 and that the upper half shows the held page. They also check that the held page moves only at a detected strobe release and then takes the port value, and that reset clears it. Only the bench scenarios show the one-fetch delay in terms of port timing. They also show that port changes made during a low strobe are lost when the port changes again before the release, and that long random runs of mixed fetches track a model that updates only at strobe releases.

// File: rtl/codebank_map.sv
module codebank_map #(
  parameter int PAGE_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fetch_strobe_n,
  input  logic                 cpu_addr_hi,
  input  logic [PAGE_BITS-1:0] page_sel,
  output logic [PAGE_BITS-1:0] mem_page
);

  localparam logic [PAGE_BITS-1:0] COMMON_PAGE = '0;

  logic                 strobe_q;
  logic                 release_evt;
  logic [PAGE_BITS-1:0] bank_q;

  assign release_evt = fetch_strobe_n & ~strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b1;
      bank_q   <= COMMON_PAGE;
    end else begin
      strobe_q <= fetch_strobe_n;
      if (release_evt) bank_q <= page_sel;
    end
  end

  assign mem_page = cpu_addr_hi ? bank_q : COMMON_PAGE;

  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> bank_q == COMMON_PAGE);

  a_r2_low_half_common: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_addr_hi |-> mem_page == COMMON_PAGE);

  a_r3_upper_follows_bank: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr_hi |-> mem_page == bank_q);

  a_r4_hold_without_release: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_strobe_n && !strobe_q) |=> $stable(bank_q));

  a_r5_capture_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_strobe_n && !strobe_q) |=> bank_q == $past(page_sel));

  a_r7_fall_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fetch_strobe_n) |=> $stable(bank_q));

endmodule

// File: tb/tb_codebank_map.sv
module tb_codebank_map;
  localparam int PERIOD = 10;
  localparam int PB = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fetch_strobe_n = 1'b1;
  logic          cpu_addr_hi = 1'b0;
  logic [PB-1:0] page_sel = '0;
  logic [PB-1:0] mem_page;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [PB-1:0] model_bank = '0;

  codebank_map #(.PAGE_BITS(PB)) dut (
    .clk(clk), .rst_n(rst_n), .fetch_strobe_n(fetch_strobe_n),
    .cpu_addr_hi(cpu_addr_hi), .page_sel(page_sel), .mem_page(mem_page)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [PB-1:0] exp_page(input logic hi, input logic [PB-1:0] bank);
    return hi ? bank : '0;
  endfunction

  task automatic check(input string req, input logic [PB-1:0] expv);
    checks++;
    if (mem_page !== expv) begin
      fails++;
      $display("FAIL %s: mem_page=%0h expected=%0h", req, mem_page, expv);
    end
  endtask

  task automatic probe(input string req);
    cpu_addr_hi = 1'b0; #1;
    check(req, exp_page(1'b0, model_bank));
    cpu_addr_hi = 1'b1; #1;
    check(req, exp_page(1'b1, model_bank));
  endtask

  task automatic strobe_cycle(input logic [PB-1:0] v, input logic [PB-1:0] during);
    @(negedge clk); page_sel = during; fetch_strobe_n = 1'b0;
    #1; probe("R7");
    @(negedge clk); page_sel = v; fetch_strobe_n = 1'b1;
    #1; probe("R6");
    @(negedge clk); model_bank = v;
    #1; probe("R5");
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    #1; probe("R1");
    rst_n = 1'b1;
    @(negedge clk); #1; probe("R1");
    page_sel = 4'hA;
    @(negedge clk); #1; probe("R4");
    strobe_cycle(4'hF, 4'h3);
    strobe_cycle(4'h0, 4'h9);
    strobe_cycle(4'h7, 4'h7);
    for (int i = 0; i < 400; i++) begin
      logic [PB-1:0] v;
      v = PB'($urandom);
      if ($urandom_range(0, 2) == 0) begin
        @(negedge clk); page_sel = v; #1; probe("R4");
      end else begin
        strobe_cycle(v, PB'($urandom));
      end
      cpu_addr_hi = 1'($urandom); #1;
      check(cpu_addr_hi ? "R3" : "R2", exp_page(cpu_addr_hi, model_bank));
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule